// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire Block Protocol)

This block is the control-plane endpoint of a clock synthesizer. It listens on a two-wire I2C bus (SCL input, SDA input and an open-drain SDA pull-down) and keeps six 8-bit configuration bytes. These bytes steer the synthesizer: which frequency code is used, whether spread-spectrum modulation runs and how wide it is, whether all clock outputs float, and which individual clock outputs are enabled. The block does not generate any clocks itself.

The protocol has no register address. A host writes by sending the device write address, then a command byte and a count byte, and both of those are discarded. The data bytes that follow always fill the configuration bytes from index 0 upward. A host reads by sending the device read address. The block then returns a count byte followed by the configuration bytes in index order. At power-on the block samples four frequency-strap pins and keeps them. The inverted strap levels show up as read-only bits inside three of the configuration bytes.

Both bus lines are brought into the system clock domain through a synchronizer. The system clock must run at least sixteen times the bus bit rate.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The 8-bit address byte 0xD2 (write) and 0xD3 (read) are acknowledged by pulling SDA low in the ninth bit. Any other address byte is not acknowledged, and the rest of that transaction changes nothing.
- R2: In a write, the two bytes after the address (command and count) are acknowledged and change no configuration byte.
- R3: Data bytes after the count land in configuration bytes 0, 1, 2, 3, 4, 5 in that order, and each one is acknowledged. Data bytes beyond the sixth are acknowledged and discarded without wrapping to byte 0.
- R4: A write ended by STOP after any complete byte leaves every configuration byte it did not reach at its previous value.
- R5: In a read, the block first sends a count byte of value 6, then configuration bytes 0 to 5, most significant bit first. It continues while the master acknowledges, and it sends 0xFF for every byte requested past byte 5.
- R6: After reset the writable bits hold these values: byte 0 = 0x00, bytes 1 and 2 = 0x7F, bytes 3 and 5 = 0xFF, byte 4 = 0xF5. Output `cfg_o` carries byte i on bits [8i+7:8i].
- R7: Four bits are read-only and return the inverted latched straps. These are byte 1 bit 7 = ~strap[2], byte 2 bit 7 = ~strap[0], byte 4 bit 3 = ~strap[1], and byte 4 bit 1 = ~strap[3]. Writes to these bits are ignored.
- R8: When byte 0 bit 3 is 0, `freq_code_o` equals the latched strap value and `freq_from_reg_o` is 0. When bit 3 is 1, `freq_code_o` = {bit 2, bit 6, bit 5, bit 4} of byte 0 and `freq_from_reg_o` is 1.
- R9: `spread_en_o` follows byte 0 bit 1, `spread_wide_o` follows byte 0 bit 7 (1 selects 0.5 %, 0 selects 0.25 %), and `outputs_off_o` follows byte 0 bit 0.
- R10: A repeated START in the middle of a write resets the byte pointer, so the first data byte of the next write goes to byte 0 again.
- R11: `strap_i` is captured while `rst_n` is low. Changes on `strap_i` after reset affect neither `strap_lat_o` nor the read-only bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 4 | Frequency strap pins {FS3,FS2,FS1,FS0} |
| cfg_o | output | 48 | Six configuration bytes, byte i at [8i+7:8i] |
| strap_lat_o | output | 4 | Latched strap levels |
| freq_code_o | output | 4 | Selected frequency code |
| freq_from_reg_o | output | 1 | 1 when the frequency code comes from byte 0 |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_wide_o | output | 1 | 1 = 0.5 % spread, 0 = 0.25 % |
| outputs_off_o | output | 1 | 1 = tristate all clock outputs |

## Verification
Two situations are hard to reach from the ports. One is a write that runs past the last configuration byte. The other is a repeated START that lands in the middle of a write. In both, the byte pointer must saturate or restart instead of wrapping, and nothing shows this except a later register value. The bench therefore drives the bit-banged master into both situations: an overlong burst of eight data bytes, and a write cut short by a second START. It then reads the whole set back over the bus and on `cfg_o`. Writes of all ones and all zeros into the strap-backed bits, with straps chosen so that the inverted value differs, show that those bits ignore writes.

// File: rtl/clkcfg_pkg.sv
// Package: shared constants, state type and per-byte reset/mask tables for
// the configuration slave. Assumes the strap vector is {FS3,FS2,FS1,FS0}.
package clkcfg_pkg;

    localparam int BYTE_W    = 8;
    localparam int STRAP_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    // Power-on value of the writable bits of byte idx (read-only bits zero).
    function automatic logic [BYTE_W-1:0] byte_default(input int idx);
        case (idx)
            0:       byte_default = 8'h00;
            1, 2:    byte_default = 8'h7F;
            4:       byte_default = 8'hF5;
            default: byte_default = 8'hFF;
        endcase
    endfunction

    // Mask of the strap-backed (read-only) bits of byte idx.
    function automatic logic [BYTE_W-1:0] ro_mask(input int idx);
        case (idx)
            1, 2:    ro_mask = 8'h80;
            4:       ro_mask = 8'h0A;
            default: ro_mask = 8'h00;
        endcase
    endfunction

    // Inverted strap levels placed at the read-only positions of byte idx.
    function automatic logic [BYTE_W-1:0] strap_bits(input int idx,
                                                     input logic [STRAP_W-1:0] s);
        logic [BYTE_W-1:0] v;
        v = '0;
        case (idx)
            1: v[7] = ~s[2];
            2: v[7] = ~s[0];
            4: begin
                v[3] = ~s[1];
                v[1] = ~s[3];
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
// Brings SCL/SDA into the clk domain and flags edges and bus conditions.
// Assumes clk runs at least 16x the bit rate; lines idle high.
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_prev;
    logic            sda_prev;

    // Shift both lines through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_o    = scl_pipe[STAGES-1];
    assign sda_o    = sda_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_prev = sda_pipe[STAGES];

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

    assert_start_stop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

endmodule

// File: rtl/clkcfg_bus_engine.sv
// Bit/byte protocol engine: address match, discarding of the command and
// count bytes, sequential write strobes, and the block-read byte stream.
// Assumes synchronized inputs from clkcfg_line_sync.
module clkcfg_bus_engine
    import clkcfg_pkg::*;
#(
    parameter int          NUM_REGS = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int         IW       = $clog2(NUM_REGS),
    localparam int         CW       = $clog2(NUM_REGS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [IW-1:0]     rd_idx,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [IW-1:0]     reg_widx,
    output logic [BYTE_W-1:0] reg_wdata
);
    localparam logic [CW-1:0] CNT_MAX   = CW'(NUM_REGS + 2);
    localparam logic [CW-1:0] FIRST_DAT = CW'(2);
    localparam logic [CW-1:0] LAST_RD   = CW'(NUM_REGS);
    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);

    bus_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [CW-1:0]     byte_cnt;
    logic              is_read;
    logic              ack_seen;
    logic [BYTE_W-1:0] tx_byte;
    logic [CW-1:0]     cnt_next;

    // Choose the byte to transmit from the current read position.
    always_comb begin
        rd_idx = IW'(byte_cnt - CW'(1));
        if (byte_cnt == '0)
            tx_byte = COUNT_BYTE;
        else if (byte_cnt <= LAST_RD)
            tx_byte = rd_byte;
        else
            tx_byte = 8'hFF;
        cnt_next = (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + CW'(1);
    end

    // Protocol state machine, advanced on synchronized SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_cnt  <= '0;
            is_read   <= 1'b0;
            ack_seen  <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_widx  <= '0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_ev) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                                if (byte_cnt >= FIRST_DAT && byte_cnt < CNT_MAX) begin
                                    reg_we    <= 1'b1;
                                    reg_widx  <= IW'(byte_cnt - FIRST_DAT);
                                    reg_wdata <= shreg;
                                end
                                byte_cnt <= cnt_next;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                shreg    <= tx_byte;
                                sda_oe   <= ~tx_byte[7];
                                bit_cnt  <= '0;
                                byte_cnt <= cnt_next;
                                state    <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_MACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b1};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            ack_seen <= ~sda;
                        end else if (scl_fall) begin
                            if (ack_seen) begin
                                shreg    <= tx_byte;
                                sda_oe   <= ~tx_byte[7];
                                bit_cnt  <= '0;
                                byte_cnt <= cnt_next;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && !start_ev && !stop_ev
         && shreg[7:1] != DEV_ADDR) |=> !sda_oe);

    assert_skip_cmd_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (byte_cnt > FIRST_DAT));

    assert_hold_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && !start_ev && !stop_ev) |=> $stable(sda_oe));

    assert_restart_pointer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR && byte_cnt == '0));

endmodule

// File: rtl/clkcfg_regs.sv
// Configuration byte storage with power-on defaults, strap capture and the
// strap-backed read-only bits. Assumes straps are stable while rst_n is low.
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int  NUM_REGS = 6,
    localparam int IW       = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [STRAP_W-1:0]         strap_i,
    input  logic                       we,
    input  logic [IW-1:0]              widx,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic [IW-1:0]              rd_idx,
    output logic [BYTE_W-1:0]          rd_byte,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o,
    output logic [STRAP_W-1:0]         strap_o
);
    logic [STRAP_W-1:0] strap_q;
    logic [BYTE_W-1:0]  store_q [NUM_REGS];
    logic [BYTE_W-1:0]  vis     [NUM_REGS];

    // Capture strap pins for as long as reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_byte
            localparam logic [BYTE_W-1:0] MASK = ro_mask(g);

            // Writable bits of one byte: default on reset, load on strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    store_q[g] <= byte_default(g) & ~MASK;
                else if (we && widx == IW'(g))
                    store_q[g] <= wdata & ~MASK;
            end

            assign vis[g] = (store_q[g] & ~MASK) | (strap_bits(g, strap_q) & MASK);
            assign regs_o[g*BYTE_W +: BYTE_W] = vis[g];

            assert_keep_unwritten_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && widx == IW'(g)) |=> $stable(store_q[g]));
        end
    endgenerate

    // Read port for the block-read stream; out-of-range reads as all ones.
    always_comb begin
        rd_byte = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IW'(i)) rd_byte = vis[i];
    end

    assign strap_o = strap_q;

    assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (32'(widx) < NUM_REGS));

    assert_strap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

endmodule

// File: rtl/clkcfg_decode.sv
// Turns configuration byte 0 and the latched straps into synthesizer
// controls. Purely combinational.
module clkcfg_decode
    import clkcfg_pkg::*;
(
    input  logic [BYTE_W-1:0]  ctrl_byte,
    input  logic [STRAP_W-1:0] strap,
    output logic [STRAP_W-1:0] freq_code,
    output logic               freq_from_reg,
    output logic               spread_en,
    output logic               spread_wide,
    output logic               outputs_off
);
    // Frequency source selection and single-bit control fields.
    always_comb begin
        freq_from_reg = ctrl_byte[3];
        freq_code     = ctrl_byte[3] ? {ctrl_byte[2], ctrl_byte[6], ctrl_byte[5], ctrl_byte[4]}
                                     : strap;
        spread_en     = ctrl_byte[1];
        spread_wide   = ctrl_byte[7];
        outputs_off   = ctrl_byte[0];
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
// Top level: two-wire configuration slave for a clock synthesizer.
// Assumes clk >= 16x bus bit rate; SDA is open drain (sda_oe_o pulls low).
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS    = 6,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    localparam int        IW          = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [STRAP_W-1:0]         strap_i,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o,
    output logic [STRAP_W-1:0]         strap_lat_o,
    output logic [STRAP_W-1:0]         freq_code_o,
    output logic                       freq_from_reg_o,
    output logic                       spread_en_o,
    output logic                       spread_wide_o,
    output logic                       outputs_off_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] rd_byte;
    logic [IW-1:0]     rd_idx;
    logic              reg_we;
    logic [IW-1:0]     reg_widx;
    logic [BYTE_W-1:0] reg_wdata;

    clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    clkcfg_bus_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .rd_byte(rd_byte), .rd_idx(rd_idx), .sda_oe(sda_oe_o),
        .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata)
    );

    clkcfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .we(reg_we), .widx(reg_widx), .wdata(reg_wdata),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .regs_o(cfg_o), .strap_o(strap_lat_o)
    );

    clkcfg_decode u_decode (
        .ctrl_byte(cfg_o[BYTE_W-1:0]), .strap(strap_lat_o),
        .freq_code(freq_code_o), .freq_from_reg(freq_from_reg_o),
        .spread_en(spread_en_o), .spread_wide(spread_wide_o),
        .outputs_off(outputs_off_o)
    );

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
// Directed bench: a bit-banged master drives each scenario from its own task.
module clkcfg_i2c_slave_bench;
    localparam int Q = 10;   // quarter bit period in clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic [3:0]  strap = 4'b1010;
    logic        sda_oe;
    logic [47:0] cfg;
    logic [3:0]  strap_lat, freq_code;
    logic        from_reg, sp_en, sp_wide, off;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_slave u_clkcfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .cfg_o(cfg), .strap_lat_o(strap_lat), .freq_code_o(freq_code),
        .freq_from_reg_o(from_reg), .spread_en_o(sp_en), .spread_wide_o(sp_wide),
        .outputs_off_o(off)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(1);
            scl_m = 1'b1; wait_q(2);
            scl_m = 1'b0; wait_q(1);
        end
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        ack = ~sda_line;
        wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1);
            scl_m = 1'b1; wait_q(1);
            b[i] = sda_line;
            wait_q(1);
            scl_m = 1'b0;
        end
        wait_q(1);
        sda_m = ~give_ack; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
        sda_m = 1'b1;
    endtask

    // Write with header; n data bytes taken from d (byte k at [8k+7:8k]).
    task automatic write_burst(input int n, input logic [63:0] d, input string req);
        logic a;
        bus_start;
        put_byte(8'hD2, a); check({req, " addr ack"}, a, 1);
        put_byte(8'h5A, a); check("R2 command ack", a, 1);
        put_byte(8'h03, a); check("R2 count ack", a, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(d[8*k +: 8], a); check({req, " data ack"}, a, 1);
        end
    endtask

    task automatic t_reset;
        check("R6 reset cfg", cfg, 48'hFF_F5_FF_FF_FF_00);
        check("R11 strap latched", strap_lat, 4'b1010);
        check("R8 strap freq", {from_reg, freq_code}, 5'b0_1010);
        check("R9 reset controls", {sp_en, sp_wide, off}, 3'b000);
        check("R1 idle sda", sda_oe, 0);
        strap = 4'b0101; wait_q(2);
        check("R11 strap pins ignored", strap_lat, 4'b1010);
        check("R7 R11 ro bits after pin change", cfg, 48'hFF_F5_FF_FF_FF_00);
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start;
        put_byte(8'hA0, a); check("R1 foreign addr nack", a, 0);
        put_byte(8'h11, a); check("R1 foreign data nack", a, 0);
        bus_stop;
        bus_start;
        put_byte(8'hD0, a); check("R1 near addr nack", a, 0);
        bus_stop;
        check("R1 no change", cfg, 48'hFF_F5_FF_FF_FF_00);
    endtask

    task automatic t_full_write;
        write_burst(6, 64'h3C_00_A5_12_00_86, "R3");
        bus_stop;
        // r1 bit7 = ~FS2 = 1, r2 bit7 = ~FS0 = 1, r4 bits 3,1 = ~FS1,~FS3 = 0
        check("R3 R7 full write", cfg, 48'h3C_00_A5_92_80_86);
        check("R8 strap still selects", {from_reg, freq_code}, 5'b0_1010);
        check("R9 spread on wide", {sp_en, sp_wide, off}, 3'b110);
    endtask

    task automatic t_read(input logic [47:0] exp);
        logic a;
        logic [7:0] b;
        bus_start;
        put_byte(8'hD3, a); check("R1 read addr ack", a, 1);
        get_byte(1'b1, b); check("R5 count byte", b, 8'd6);
        for (int k = 0; k < 6; k++) begin
            get_byte(1'b1, b); check("R5 read byte", b, exp[8*k +: 8]);
        end
        get_byte(1'b1, b); check("R5 past end", b, 8'hFF);
        get_byte(1'b0, b); check("R5 past end again", b, 8'hFF);
        bus_stop;
        check("R5 read no change", cfg, exp);
    endtask

    task automatic t_partial;
        write_burst(2, 64'h7F_09, "R4");
        bus_stop;
        check("R4 partial write", cfg, 48'h3C_00_A5_92_FF_09);
        check("R8 reg code zero", {from_reg, freq_code}, 5'b1_0000);
        check("R9 tristate", {sp_en, sp_wide, off}, 3'b001);
    endtask

    task automatic t_decode;
        write_burst(1, 64'h5C, "R8");
        bus_stop;
        check("R8 reg code", {from_reg, freq_code}, 5'b1_1101);
        check("R9 all off", {sp_en, sp_wide, off}, 3'b000);
        check("R4 single byte", cfg, 48'h3C_00_A5_92_FF_5C);
    endtask

    task automatic t_restart;
        write_burst(1, 64'h11, "R10");
        write_burst(1, 64'h22, "R10");
        bus_stop;
        check("R10 restart pointer", cfg, 48'h3C_00_A5_92_FF_22);
    endtask

    task automatic t_overrun;
        write_burst(8, 64'hEF_EE_05_FF_03_02_01_00, "R3");
        bus_stop;
        // r1 bit7 forced 1, r4 0xFF -> F5, extra EE/EF must not reach r0
        check("R3 R7 overrun", cfg, 48'h05_F5_03_82_81_00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_bad_addr;
        t_full_write;
        t_read(48'h3C_00_A5_92_80_86);
        t_partial;
        t_decode;
        t_restart;
        t_overrun;
        t_read(48'h05_F5_03_82_81_00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule